// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter, as a processor sees it. Software programs one 8-bit control byte over a small synchronous read/write bus. The byte picks one of eight analog inputs and one of four conversion rates, and it starts a conversion. Software then polls a completion flag and reads the 10-bit code back through two read-only bytes. The analog multiplexer, the trial DAC and the comparator sit outside the block. The block drives the multiplexer select and the DAC code, and it samples the comparator as a single-bit input.

A conversion has two phases. First comes a settling phase of 10 conversion-clock periods. Then come ten bit decisions, most significant bit first, each lasting 4 conversion-clock periods. A prescaler produces the conversion rate as a one-cycle enable in the system clock domain. The rate is the system clock divided by 16, 8, 4 or 1. No second clock exists anywhere in the block. The channel and rate fields are captured when a conversion begins, so software may rewrite them freely while a conversion runs.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control byte (address 0), both result bytes (addresses 1 and 2) and `dac_code` all read 0, and no conversion runs.
- R2: Control byte layout: bits [6:4] are the channel, bit [3] is completion, bits [2:1] are the rate select and bit [0] is start. Bit 7 always reads 0, and a write stores the channel and rate fields.
- R3: The completion bit ignores bus writes. A write of start=1 to an idle block clears it, and it becomes 1 in the cycle in which the conversion finishes.
- R4: Rate select values 0, 1, 2 and 3 give divisors D of 16, 8, 4 and 1. Take the clock edge that captures the start write as edge 0. Completion first reads 1 after edge 1+50·D.
- R5: The sequence has 10 settling ticks with `dac_code` at 0, then 4 ticks per bit, MSB first. During a bit, `dac_code` equals the bits kept so far with the trial bit set. The comparator is sampled on the 4th tick, and the bit is kept when `cmp_in` is 1. `dac_code` is 0 while idle.
- R6: With a comparator that reports input ≥ DAC code, the result equals the input code. Address 1 returns result[9:2], and address 2 returns result[1:0] in bits [1:0] with zeros above. Both are updated on the same edge that sets completion.
- R7: `chan_sel` carries the channel field captured at start; codes 0 to 7 select inputs 0 to 7.
- R8: Rewriting the channel or rate field during a conversion changes neither `chan_sel`, nor the result, nor the latency of that conversion.
- R9: The start bit reads 1 only until the conversion begins, one cycle after the write. A start write made while a conversion runs is ignored.
- R10: The sequencer advances only on the prescaler's one-cycle tick, and the tick occurs only during a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Byte address: 0 control, 1 result high, 2 result low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_in | input | 1 | Comparator: 1 when analog input ≥ DAC level |
| dac_code | output | 10 | Trial code to the DAC |
| chan_sel | output | 3 | Analog multiplexer select |

## Verification
The bench builds the block with its default parameters: 10 result bits, 10 settling ticks, 4 ticks per bit, eight channels and divisors 16/8/4/1. These values keep the slowest conversion near 800 cycles, so every rate select can be timed exactly and a mid-conversion rewrite can be tried within a short run. A behavioural comparator tied to a per-channel code makes the full-scale, zero, half-scale and alternating-bit codes reachable. The same setup lets the bench observe the trial codes of the first two bit decisions at the divide-by-1 rate.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SETUP = 2'd1,
        SEQ_CONV  = 2'd2
    } seq_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RES_HI = 2'd1;
    localparam logic [1:0] ADDR_RES_LO = 2'd2;

    localparam int RATE_W = 2;

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int DIV_S0 = 16,
    parameter int DIV_S1 = 8,
    parameter int DIV_S2 = 4,
    parameter int DIV_S3 = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic [sar_pkg::RATE_W-1:0] rate_sel,
    output logic                      tick
);
    localparam int CNT_W = (DIV_S0 > 1) ? $clog2(DIV_S0) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t             st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        case (rate_sel)
            2'd0:    last = CNT_W'(DIV_S0 - 1);
            2'd1:    last = CNT_W'(DIV_S1 - 1);
            2'd2:    last = CNT_W'(DIV_S2 - 1);
            default: last = CNT_W'(DIV_S3 - 1);
        endcase
        tick = run && (st_q.cnt == last);
        st_d = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int RES_BITS      = 10,
    parameter int SETUP_TICKS   = 10,
    parameter int TICKS_PER_BIT = 4,
    parameter int CHAN_BITS     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_req,
    input  logic                       tick,
    input  logic                       cmp_in,
    input  logic [CHAN_BITS-1:0]       chan_field,
    input  logic [sar_pkg::RATE_W-1:0] rate_field,
    output logic                       busy,
    output logic                       go,
    output logic                       done,
    output logic [RES_BITS-1:0]        result,
    output logic [RES_BITS-1:0]        dac_code,
    output logic [CHAN_BITS-1:0]       chan_sel,
    output logic [sar_pkg::RATE_W-1:0] rate_sel
);
    import sar_pkg::*;

    localparam int MAX_TICKS = (SETUP_TICKS > TICKS_PER_BIT) ? SETUP_TICKS : TICKS_PER_BIT;
    localparam int TCNT_W    = $clog2(MAX_TICKS + 1);
    localparam int IDX_W     = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam logic [TCNT_W-1:0] SETUP_LAST = TCNT_W'(SETUP_TICKS - 1);
    localparam logic [TCNT_W-1:0] BIT_LAST   = TCNT_W'(TICKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0]  MSB_IDX    = IDX_W'(RES_BITS - 1);

    typedef struct packed {
        seq_state_e           state;
        logic [TCNT_W-1:0]    tcnt;
        logic [IDX_W-1:0]     idx;
        logic [RES_BITS-1:0]  work;
        logic [RES_BITS-1:0]  result;
        logic [CHAN_BITS-1:0] chan;
        logic [RATE_W-1:0]    rate;
    } seq_t;

    seq_t                st_d, st_q;
    logic [RES_BITS-1:0] trial_bit;
    logic [RES_BITS-1:0] decided;

    always_comb begin
        st_d      = st_q;
        go        = 1'b0;
        done      = 1'b0;
        trial_bit = RES_BITS'(1) << st_q.idx;
        decided   = cmp_in ? (st_q.work | trial_bit) : st_q.work;

        case (st_q.state)
            SEQ_IDLE: begin
                if (start_req) begin
                    go         = 1'b1;
                    st_d.state = SEQ_SETUP;
                    st_d.tcnt  = '0;
                    st_d.work  = '0;
                    st_d.idx   = MSB_IDX;
                    st_d.chan  = chan_field;
                    st_d.rate  = rate_field;
                end
            end
            SEQ_SETUP: begin
                if (tick) begin
                    if (st_q.tcnt == SETUP_LAST) begin
                        st_d.state = SEQ_CONV;
                        st_d.tcnt  = '0;
                        st_d.idx   = MSB_IDX;
                    end else begin
                        st_d.tcnt = st_q.tcnt + TCNT_W'(1);
                    end
                end
            end
            SEQ_CONV: begin
                if (tick) begin
                    if (st_q.tcnt == BIT_LAST) begin
                        st_d.tcnt = '0;
                        st_d.work = decided;
                        if (st_q.idx == '0) begin
                            done        = 1'b1;
                            st_d.result = decided;
                            st_d.state  = SEQ_IDLE;
                        end else begin
                            st_d.idx = st_q.idx - IDX_W'(1);
                        end
                    end else begin
                        st_d.tcnt = st_q.tcnt + TCNT_W'(1);
                    end
                end
            end
            default: st_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.state != SEQ_IDLE);
    assign result   = st_q.result;
    assign dac_code = (st_q.state == SEQ_CONV) ? (st_q.work | trial_bit) : '0;
    assign chan_sel = st_q.chan;
    assign rate_sel = st_q.rate;

endmodule

// File: rtl/sar_regs.sv
module sar_regs #(
    parameter int RES_BITS  = 10,
    parameter int CHAN_BITS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [1:0]                 bus_addr,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 bus_rdata,
    input  logic                       busy,
    input  logic                       go,
    input  logic                       done,
    input  logic [RES_BITS-1:0]        result,
    output logic                       start_req,
    output logic                       eoc,
    output logic [CHAN_BITS-1:0]       chan_field,
    output logic [sar_pkg::RATE_W-1:0] rate_field
);
    import sar_pkg::*;

    localparam int LO_W = RES_BITS - 8;

    typedef struct packed {
        logic [CHAN_BITS-1:0] chan;
        logic [RATE_W-1:0]    rate;
        logic                 start;
        logic                 eoc;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  ctrl_wr;
    logic  unused_wbits;

    assign unused_wbits = ^{bus_wdata[7], bus_wdata[3]};

    always_comb begin
        st_d    = st_q;
        ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
        if (ctrl_wr) begin
            st_d.chan = bus_wdata[4 +: CHAN_BITS];
            st_d.rate = bus_wdata[2:1];
            if (bus_wdata[0] && !busy) begin
                st_d.start = 1'b1;
                st_d.eoc   = 1'b0;
            end
        end
        if (go) begin
            st_d.start = 1'b0;
        end
        if (done) begin
            st_d.eoc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:   bus_rdata = {1'b0, st_q.chan, st_q.eoc, st_q.rate, st_q.start};
            ADDR_RES_HI: bus_rdata = result[RES_BITS-1 -: 8];
            ADDR_RES_LO: bus_rdata = {{(8-LO_W){1'b0}}, result[LO_W-1:0]};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign start_req  = st_q.start;
    assign eoc        = st_q.eoc;
    assign chan_field = st_q.chan;
    assign rate_field = st_q.rate;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int RES_BITS      = 10,
    parameter int SETUP_TICKS   = 10,
    parameter int TICKS_PER_BIT = 4,
    parameter int CHAN_BITS     = 3,
    parameter int DIV_S0        = 16,
    parameter int DIV_S1        = 8,
    parameter int DIV_S2        = 4,
    parameter int DIV_S3        = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 cmp_in,
    output logic [RES_BITS-1:0]  dac_code,
    output logic [CHAN_BITS-1:0] chan_sel
);
    import sar_pkg::*;

    logic                 seq_busy;
    logic                 seq_go;
    logic                 seq_done;
    logic                 pre_tick;
    logic                 ctrl_start;
    logic                 ctrl_eoc;
    logic [RES_BITS-1:0]  seq_result;
    logic [CHAN_BITS-1:0] ctrl_chan;
    logic [RATE_W-1:0]    ctrl_rate;
    logic [RATE_W-1:0]    run_rate;

    sar_regs #(
        .RES_BITS  (RES_BITS),
        .CHAN_BITS (CHAN_BITS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (seq_busy),
        .go         (seq_go),
        .done       (seq_done),
        .result     (seq_result),
        .start_req  (ctrl_start),
        .eoc        (ctrl_eoc),
        .chan_field (ctrl_chan),
        .rate_field (ctrl_rate)
    );

    sar_prescaler #(
        .DIV_S0 (DIV_S0),
        .DIV_S1 (DIV_S1),
        .DIV_S2 (DIV_S2),
        .DIV_S3 (DIV_S3)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_busy),
        .rate_sel (run_rate),
        .tick     (pre_tick)
    );

    sar_sequencer #(
        .RES_BITS      (RES_BITS),
        .SETUP_TICKS   (SETUP_TICKS),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .CHAN_BITS     (CHAN_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (ctrl_start),
        .tick       (pre_tick),
        .cmp_in     (cmp_in),
        .chan_field (ctrl_chan),
        .rate_field (ctrl_rate),
        .busy       (seq_busy),
        .go         (seq_go),
        .done       (seq_done),
        .result     (seq_result),
        .dac_code   (dac_code),
        .chan_sel   (chan_sel),
        .rate_sel   (run_rate)
    );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int RES_BITS  = 10,
    parameter int CHAN_BITS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [1:0]           bus_addr,
    input logic [7:0]           bus_wdata,
    input logic [7:0]           bus_rdata,
    input logic                 busy,
    input logic                 tick,
    input logic                 done,
    input logic                 eoc,
    input logic                 start_q,
    input logic [RES_BITS-1:0]  dac_code,
    input logic [CHAN_BITS-1:0] chan_sel
);
    logic start_wr_idle;
    assign start_wr_idle = bus_wr && (bus_addr == 2'd0) && bus_wdata[0] && !busy;

    p_bit7_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[7] == 1'b0));

    p_eoc_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !start_wr_idle) |=> $stable(eoc));

    p_done_sets_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (eoc && !busy));

    p_dac_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0));

    p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(chan_sel));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !start_q);

    p_tick_in_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> busy);

    p_eoc_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> $past(tick));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
    .RES_BITS  (RES_BITS),
    .CHAN_BITS (CHAN_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (seq_busy),
    .tick      (pre_tick),
    .done      (seq_done),
    .eoc       (ctrl_eoc),
    .start_q   (ctrl_start),
    .dac_code  (dac_code),
    .chan_sel  (chan_sel)
);

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [2:0] chan_sel;

    logic [9:0] vin [8];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int exp_lat [$];
    int exp_res [$];
    bit meas_on   = 0;
    bit conv_seen = 0;
    int cyc       = 0;

    always #4 clk = ~clk;

    assign cmp_in = (vin[chan_sel] >= dac_code);

    sar_adc_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .chan_sel  (chan_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int divisor(input logic [1:0] s);
        case (s)
            2'd0:    return 16;
            2'd1:    return 8;
            2'd2:    return 4;
            default: return 1;
        endcase
    endfunction

    // Monitor: times completion against the expected latency from the queue.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (meas_on) begin
                cyc++;
                if (bus_addr == 2'd0 && bus_rdata[3]) begin
                    int e;
                    meas_on = 0;
                    e = exp_lat.pop_front();
                    chk(cyc == e, "R4 completion latency", cyc, e);
                    conv_seen = 1;
                end
            end
        end
    end

    // Driver: one conversion, with optional probes.
    task automatic run_conv(input logic [2:0] ch, input logic [1:0] rs, input logic [9:0] v,
                            input bit probe_dac, input bit midwrite);
        logic [7:0] d;
        logic [7:0] hi;
        logic [7:0] lo;
        int         e;
        vin[ch] = v;
        exp_lat.push_back(50 * divisor(rs) + 2);
        exp_res.push_back(int'(v));
        conv_seen = 0;
        wr(2'd0, {1'b0, ch, 1'b0, rs, 1'b1});
        cyc = 0;
        meas_on = 1;
        rd(2'd0, d);
        chk(d[3] == 1'b0, "R3 completion cleared by start", d[3], 0);
        chk(d[0] == 1'b1, "R9 start held until conversion begins", d[0], 1);
        rd(2'd0, d);
        chk(d[0] == 1'b0, "R9 start self-clears", d[0], 0);
        chk(chan_sel == ch, "R7 channel select output", chan_sel, ch);
        if (probe_dac) begin
            repeat (10) @(negedge clk);
            #1;
            chk(dac_code == 10'h200, "R5 first trial code is MSB", dac_code, 10'h200);
            repeat (4) @(negedge clk);
            #1;
            chk(dac_code == {v[9], 9'h100}, "R5 second trial keeps decided MSB",
                dac_code, {v[9], 9'h100});
        end
        if (midwrite) begin
            repeat (20) @(negedge clk);
            wr(2'd0, {1'b0, ~ch, 1'b0, 2'b11, 1'b1});
            rd(2'd0, d);
            chk(d[0] == 1'b0, "R9 start write ignored while busy", d[0], 0);
            chk(d[6:4] == ~ch, "R2 channel field written", d[6:4], ~ch);
            chk(chan_sel == ch, "R8 channel output held mid-conversion", chan_sel, ch);
        end
        while (!conv_seen) @(negedge clk);
        rd(2'd1, hi);
        rd(2'd2, lo);
        e = exp_res.pop_front();
        chk({hi, lo[1:0]} == e[9:0], "R6 result code", {hi, lo[1:0]}, e);
        chk(lo[7:2] == 6'd0, "R6 low byte upper bits zero", lo, lo & 8'h03);
        chk(dac_code == 10'd0, "R5 DAC code zero when idle", dac_code, 0);
        rd(2'd0, d);
        chk(d[3] == 1'b1, "R3 completion set", d[3], 1);
    endtask

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 8; i++) vin[i] = 10'(i * 97 + 3);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        rd(2'd0, d);
        chk(d == 8'h00, "R1 control after reset", d, 0);
        rd(2'd1, d);
        chk(d == 8'h00, "R1 result high after reset", d, 0);
        rd(2'd2, d);
        chk(d == 8'h00, "R1 result low after reset", d, 0);
        chk(dac_code == 10'd0, "R1 DAC code after reset", dac_code, 0);

        wr(2'd0, 8'hFE);
        rd(2'd0, d);
        chk(d == 8'h76, "R2 layout with bit7 zero and R3 completion not writable", d, 8'h76);
        repeat (5) @(negedge clk);
        #1;
        chk(dac_code == 10'd0, "R1 no conversion without start", dac_code, 0);

        run_conv(3'd0, 2'd3, 10'd0,   1'b1, 1'b0);
        run_conv(3'd1, 2'd3, 10'h3FF, 1'b1, 1'b0);
        run_conv(3'd2, 2'd2, 10'h200, 1'b0, 1'b0);
        run_conv(3'd3, 2'd1, 10'h1FF, 1'b0, 1'b0);
        run_conv(3'd7, 2'd0, 10'h2AA, 1'b0, 1'b0);
        run_conv(3'd5, 2'd3, 10'h155, 1'b1, 1'b0);
        vin[3'd6] = 10'h011;
        run_conv(3'd1, 2'd2, 10'h2D4, 1'b0, 1'b1);
        vin[3'd3] = 10'h3C0;
        run_conv(3'd4, 2'd2, 10'h0F0, 1'b0, 1'b1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule